// File: doc/BRIEF.md
# PRBS7 Link Test Pattern Source

This block sits on the transmit side of a parallel-to-serial video link, ahead of the serializer. In normal operation it registers the 24-bit pixel payload and passes it on. When a self-test is requested, it replaces that payload with a PRBS7 pseudo-random sequence. It also raises a test-active flag and sends a 2-bit command code, so that the far-end receiver knows the pattern is a test pattern and can check it for bit errors.

A test can be requested in two ways. The first is a dedicated self-test enable input. The second is a legacy entry: when the legacy enable is high, an input word that is entirely zero also requests the test. Every step is taken on a pixel clock edge, so the pixel clock must keep running throughout a test.

The control is a two-state machine:
- `ST_FORWARD` is the normal pass-through state.
- `ST_PATTERN` is the state in which the pattern is generated.

It has four named transitions:
- `T_ENTER`: from `ST_FORWARD` to `ST_PATTERN` when a request is seen.
- `T_STAY`: remain in `ST_PATTERN` while the request holds.
- `T_EXIT`: from `ST_PATTERN` to `ST_FORWARD` when the request drops.
- `T_IDLE`: remain in `ST_FORWARD` while there is no request.

Top module: `lnk_tpg_top`

## Requirements
- R1: While `rst_n` is low, `pay_out` is 0, `test_act` is 0 and `cmd_code` is 2'b00.
- R2: If `selftest_en` is high at a clock edge, then after that edge `test_act` is 1, `cmd_code` is 2'b11 and `pay_out` carries a pattern word.
- R3: Pattern generation uses a 7-bit register s and performs 24 steps per clock.
  - Each step produces the bit f = s[6] ^ s[5], which is the polynomial x^7 + x^6 + 1, and then sets s = {s[5:0], f}.
  - Bit k of the word is the bit produced by step k, so bit 0 is the oldest.
  - Consecutive test cycles continue the same sequence without a gap.
- R4: The register s holds 7'h7F after reset and in every cycle outside a test. Every test therefore starts its first word from 7'h7F, and a re-entry restarts the sequence.
- R5: With no request at an edge, `pay_out` after that edge equals the `pix_in` sampled at that edge, `test_act` is 0 and `cmd_code` is 2'b00.
- R6: With `legacy_en` high, a `pix_in` of 24'h000000 at an edge requests the test exactly as `selftest_en` does.
- R7: With `legacy_en` low, an all-zero `pix_in` has no effect: it is forwarded as a normal zero payload with `test_act` at 0.
- R8: A legacy-entered test (with `selftest_en` low) ends at the first edge at which `pix_in` is nonzero, and that word is forwarded.
- R9: `test_act` and `cmd_code` are registered and change at the same edge as the first and the last pattern word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selftest_en | input | 1 | Self-test request |
| legacy_en | input | 1 | Allows an all-zero input word to request the test |
| pix_in | input | 24 | Normal pixel payload |
| pay_out | output | 24 | Payload toward the serializer |
| test_act | output | 1 | High while pattern words are being sent |
| cmd_code | output | 2 | 2'b11 while testing, 2'b00 otherwise |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 7-bit register, taps at bits 6 and 5, and a seed of 7'h7F. With a 127-bit period and 24 bits per word, a run of about 40 consecutive test cycles wraps the sequence several times at different word offsets. This lets the bench check continuity across word boundaries as well as across the period boundary. Both entry methods, the ignored all-zero word, and re-entry from the seed are each reached within a few cycles at these values.

// File: rtl/lnk_tpg_pkg.sv
package lnk_tpg_pkg;

    localparam int unsigned PAY_W  = 24;
    localparam int unsigned SR_W   = 7;
    localparam int unsigned CMD_W  = 2;

    typedef enum logic [0:0] {
        ST_FORWARD = 1'b0,
        ST_PATTERN = 1'b1
    } tpg_state_e;

    localparam logic [CMD_W-1:0] CMD_NORMAL = 2'b00;
    localparam logic [CMD_W-1:0] CMD_TEST   = 2'b11;

endpackage

// File: rtl/lnk_tpg_req.sv
module lnk_tpg_req #(
    parameter int unsigned W = 24
) (
    input  logic         selftest_en,
    input  logic         legacy_en,
    input  logic [W-1:0] pix_in,
    output logic         req_o
);
    logic zero_word;

    always_comb begin
        zero_word = (pix_in == '0);
        req_o     = selftest_en | (legacy_en & zero_word);
    end

endmodule

// File: rtl/lnk_tpg_prbs.sv
module lnk_tpg_prbs #(
    parameter int unsigned W     = 24,
    parameter int unsigned SR_W  = 7,
    parameter int unsigned TAP_A = 6,
    parameter int unsigned TAP_B = 5
) (
    input  logic [SR_W-1:0] st_i,
    output logic [W-1:0]    word_o,
    output logic [SR_W-1:0] nxt_o
);
    logic [SR_W-1:0] walk;
    logic            fb;

    always_comb begin
        walk   = st_i;
        word_o = '0;
        fb     = 1'b0;
        for (int k = 0; k < W; k++) begin
            fb        = walk[TAP_A] ^ walk[TAP_B];
            word_o[k] = fb;
            walk      = {walk[SR_W-2:0], fb};
        end
        nxt_o = walk;
    end

    // R3: a nonzero register never steps into the all-zero lock-up state
    always_comb begin
        if (st_i != '0) begin
            p_no_lockup_r3: assert (nxt_o != '0);
        end
    end

endmodule

// File: rtl/lnk_tpg_top.sv
module lnk_tpg_top
    import lnk_tpg_pkg::*;
#(
    parameter int unsigned     W     = 24,
    parameter int unsigned     SR_W  = 7,
    parameter int unsigned     TAP_A = 6,
    parameter int unsigned     TAP_B = 5,
    parameter logic [SR_W-1:0] SEED  = 7'h7F
) (
    input  logic         clk_px,
    input  logic         rst_n,
    input  logic         selftest_en,
    input  logic         legacy_en,
    input  logic [W-1:0] pix_in,
    output logic [W-1:0] pay_out,
    output logic         test_act,
    output logic [1:0]   cmd_code
);
    tpg_state_e      state_q, state_d;
    logic            req;
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] sr_nxt;
    logic [W-1:0]    pat_word;

    lnk_tpg_req #(.W(W)) u_req (
        .selftest_en (selftest_en),
        .legacy_en   (legacy_en),
        .pix_in      (pix_in),
        .req_o       (req)
    );

    lnk_tpg_prbs #(.W(W), .SR_W(SR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_prbs (
        .st_i   (sr_q),
        .word_o (pat_word),
        .nxt_o  (sr_nxt)
    );

    // Next state: T_ENTER, T_STAY, T_EXIT, T_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FORWARD: state_d = req ? ST_PATTERN : ST_FORWARD; // T_ENTER / T_IDLE
            ST_PATTERN: state_d = req ? ST_PATTERN : ST_FORWARD; // T_STAY / T_EXIT
            default:    state_d = ST_FORWARD;
        endcase
    end

    // State register and sequence register
    always_ff @(posedge clk_px or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FORWARD;
            sr_q    <= SEED;
        end else begin
            state_q <= state_d;
            sr_q    <= (state_d == ST_PATTERN) ? sr_nxt : SEED;
        end
    end

    // Registered outputs, aligned with the state register
    always_ff @(posedge clk_px or negedge rst_n) begin
        if (!rst_n) begin
            pay_out  <= '0;
            test_act <= 1'b0;
            cmd_code <= CMD_NORMAL;
        end else begin
            unique case (state_d)
                ST_PATTERN: begin
                    pay_out  <= pat_word;
                    test_act <= 1'b1;
                    cmd_code <= CMD_TEST;
                end
                default: begin
                    pay_out  <= pix_in;
                    test_act <= 1'b0;
                    cmd_code <= CMD_NORMAL;
                end
            endcase
        end
    end

    p_enter_r2: assert property (@(posedge clk_px) disable iff (!rst_n)
        selftest_en |=> (test_act && cmd_code == 2'b11));

    p_seed_hold_r4: assert property (@(posedge clk_px) disable iff (!rst_n)
        !test_act |-> (sr_q == SEED));

    p_forward_r5: assert property (@(posedge clk_px) disable iff (!rst_n)
        (!selftest_en && !legacy_en) |=> (!test_act && cmd_code == 2'b00 && pay_out == $past(pix_in)));

    p_legacy_r6: assert property (@(posedge clk_px) disable iff (!rst_n)
        (legacy_en && pix_in == '0) |=> test_act);

    p_cmd_flag_r9: assert property (@(posedge clk_px) disable iff (!rst_n)
        test_act == (cmd_code == 2'b11));

    p_sr_step_r3: assert property (@(posedge clk_px) disable iff (!rst_n)
        (test_act && $past(test_act)) |-> (sr_q != $past(sr_q)));

endmodule

// File: tb/lnk_tpg_top_tb.sv
module lnk_tpg_top_tb;
    localparam int CLK_T = 10;

    logic        clk_px = 1'b0;
    logic        rst_n  = 1'b0;
    logic        selftest_en = 1'b0;
    logic        legacy_en   = 1'b0;
    logic [23:0] pix_in      = 24'h0;
    logic [23:0] pay_out;
    logic        test_act;
    logic [1:0]  cmd_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [23:0] pay;
        logic        act;
        logic [1:0]  cmd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [6:0]  m_sr = 7'h7F;

    always #(CLK_T/2) clk_px = ~clk_px;

    lnk_tpg_top u_dut (
        .clk_px      (clk_px),
        .rst_n       (rst_n),
        .selftest_en (selftest_en),
        .legacy_en   (legacy_en),
        .pix_in      (pix_in),
        .pay_out     (pay_out),
        .test_act    (test_act),
        .cmd_code    (cmd_code)
    );

    task automatic check_now(input logic [23:0] p, input logic a, input logic [1:0] c, input string tag);
        n_chk++;
        if (pay_out !== p || test_act !== a || cmd_code !== c) begin
            n_fail++;
            $display("FAIL %s: got pay=%h act=%b cmd=%b, expected pay=%h act=%b cmd=%b",
                     tag, pay_out, test_act, cmd_code, p, a, c);
        end
    endtask

    // Driver: apply one vector and push its expected result (R3 model)
    task automatic drive(input logic en, input logic leg, input logic [23:0] pix, input string tag);
        exp_t e;
        logic f;
        @(negedge clk_px);
        selftest_en = en;
        legacy_en   = leg;
        pix_in      = pix;
        e.tag = tag;
        if (en || (leg && pix == 24'h0)) begin
            for (int k = 0; k < 24; k++) begin
                f = m_sr[6] ^ m_sr[5];
                e.pay[k] = f;
                m_sr = {m_sr[5:0], f};
            end
            e.act = 1'b1;
            e.cmd = 2'b11;
        end else begin
            e.pay = pix;
            e.act = 1'b0;
            e.cmd = 2'b00;
            m_sr  = 7'h7F;
        end
        sb.push_back(e);
    endtask

    // Monitor: compare one item after each capturing edge
    always @(posedge clk_px) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check_now(e.pay, e.act, e.cmd, e.tag);
        end
    end

    initial begin
        #(CLK_T * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        pix_in = 24'hABCDEF;
        selftest_en = 1'b1;
        repeat (3) @(negedge clk_px);
        check_now(24'h0, 1'b0, 2'b00, "R1 reset state");
        selftest_en = 1'b0;
        rst_n = 1'b1;

        drive(0, 0, 24'h123456, "R5 forward a");
        drive(0, 1, 24'h00FF00, "R5 forward legacy nonzero");
        drive(1, 0, 24'h555555, "R2 R4 first word from seed");
        for (int i = 0; i < 40; i++) drive(1, 0, 24'h111111 * (i % 8), "R3 continuous sequence");
        drive(0, 0, 24'hA5A5A5, "R9 exit forwards word");
        drive(0, 0, 24'h000000, "R7 zero ignored without legacy");
        drive(1, 0, 24'hFFFFFF, "R9 R4 re-entry restarts");
        drive(1, 1, 24'h000001, "R3 second word");
        drive(0, 0, 24'h0F0F0F, "R5 forward b");
        drive(0, 1, 24'h000000, "R6 legacy zero enters");
        drive(0, 1, 24'h000000, "R6 legacy zero stays");
        drive(0, 1, 24'h000000, "R6 legacy third word");
        drive(0, 1, 24'h800000, "R8 legacy exit on nonzero");
        drive(0, 0, 24'h000000, "R7 zero forwarded");
        drive(0, 1, 24'h000000, "R6 legacy re-entry");
        drive(1, 1, 24'h000000, "R2 both requests");
        drive(0, 0, 24'hC3C3C3, "R5 forward c");

        repeat (3) @(negedge clk_px);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule